// File: doc/BRIEF.md
# Weight-Stationary Integer Matrix Unit

This block is a small integer matrix engine. Software-visible work is split into four separately issued commands on one valid/ready port. **Load** fills a stationary weight matrix W, optionally transposed as it is written. **Stage** fills one of two moving-operand banks. **Beat** sends the next staged row through the processing-element grid. **Drain** removes one result row from a result queue into a result accumulator.

Once loaded, the weights stay in place and serve every later beat until they are loaded again. Each bank and the weight store are filled in tiles of `TR` rows by `N` lanes, so a full load or stage takes `N/TR` commands. Each beat computes the row-vector product `y[c] = sum_k x[k]*W[k][c]` over the next row of the named bank. The result enters the queue as a full word, as its low half only, or as its high half only. Results never come back with the beat itself; a drain command fetches them.

A typical sequence is as follows. Load W once. Stage a bank. Issue `N` beats on that bank while staging the other bank. Then drain the rows, either overwriting the accumulator or adding into it. Adding lets a low-half and a high-half result, or partial sums, be combined.

Top module: `mxu_seq`

## Requirements
- R1: After reset `cmd_ready`=1, `res_valid`=0, both error flags are 0, and the result accumulator is zero.
- R2: A load command (`cmd_op`=0) with `cmd_xpose`=0 writes its tile row t, lane c (bits `[(t*N+c)*DW +: DW]`) to W row `g*TR+t`, column c. Here g counts load commands modulo `N/TR`.
- R3: A load with `cmd_xpose`=1 writes the same tile element to W row c, column `g*TR+t`, so the loaded matrix is stored transposed.
- R4: W is unchanged by stage, beat and drain commands and is reused by every beat until the next load.
- R5: A stage command (`cmd_op`=1) fills bank `cmd_bank` (0 = A, 1 = B) in tile order. The bank becomes ready after `N/TR` stage commands. Beats on that bank then consume its rows 0 to N-1 in order, after which the bank is empty again.
- R6: A beat (`cmd_op`=2) with `cmd_half` 0 or 3 queues `y[c]` as a 32-bit two's-complement word per lane c (bits `[c*AW +: AW]`). Operands are signed 8-bit values. Queue order is beat order.
- R7: `cmd_half`=1 queues only bits `AW/2-1:0` of each word, with the upper bits zero. `cmd_half`=2 queues only bits `AW-1:AW/2`, kept in place, with the lower bits zero.
- R8: A drain (`cmd_op`=3) with `cmd_acc`=0 overwrites the accumulator with the oldest queued row. In the cycle after acceptance, `res_valid` pulses for one cycle and `res_row` shows the accumulator.
- R9: A drain with `cmd_acc`=1 adds the oldest queued row lane-wise into the accumulator, wrapping modulo 2^AW.
- R10: A drain on an empty queue pulses `err_underflow` together with `res_valid` and uses zero as the drained row. A plain drain therefore clears the accumulator, and an accumulating drain leaves it unchanged.
- R11: A beat on a bank that is not fully staged is refused. It pulses `err_refused` in the next cycle, queues nothing and consumes no row.
- R12: `cmd_ready` is 0 only while a beat is presented and the result queue holds `FD` rows. Other commands are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 load, 1 stage, 2 beat, 3 drain |
| cmd_xpose | input | 1 | Load: store tile transposed |
| cmd_bank | input | 1 | Stage/beat: bank A (0) or B (1) |
| cmd_half | input | 2 | Beat: 0/3 full, 1 low half, 2 high half |
| cmd_acc | input | 1 | Drain: 1 accumulates, 0 overwrites |
| cmd_tile | input | TR*N*DW | Load/stage tile, row-major |
| res_valid | output | 1 | One-cycle pulse after each drain |
| res_row | output | N*AW | Result accumulator, lane c at [c*AW +: AW] |
| err_underflow | output | 1 | Drain found the queue empty |
| err_refused | output | 1 | Beat refused on an unready bank |

## Verification
A corrupted weight or staging entry shows as a wrong lane in the drained row of the first beat that uses it. That is one drain after the beat, and possibly many commands after the load that caused it. A slipped bank row pointer shifts every later row of that bank, and a wrong queue pointer shows as reordered or repeated rows at the very next drain. Bank readiness and queue occupancy are checked through refused beats, underflowing drains and `cmd_ready`, each visible one cycle after the command or, for `cmd_ready`, in the same cycle.

// File: rtl/mxu_pkg.sv
package mxu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STAGE = 2'd1,
    OP_BEAT  = 2'd2,
    OP_DRAIN = 2'd3
  } mxu_op_e;

  localparam logic [1:0] HALF_LOW  = 2'd1;
  localparam logic [1:0] HALF_HIGH = 2'd2;
endpackage

// File: rtl/mxu_weights.sv
module mxu_weights #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int TR = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 xpose,
  input  logic [TR*N*DW-1:0]   tile,
  output logic [N*N*DW-1:0]    w_flat
);
  localparam int GRPS = N / TR;
  localparam int GW   = (GRPS > 1) ? $clog2(GRPS) : 1;

  logic [DW-1:0] w [N][N];
  logic [GW-1:0] grp;
  logic          grp_last;

  assign grp_last = (grp == GW'(GRPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          w[i][j] <= '0;
    end else if (wr_en) begin
      for (int t = 0; t < TR; t++)
        for (int c = 0; c < N; c++) begin
          if (xpose) w[c][int'(grp) * TR + t] <= tile[(t*N + c)*DW +: DW];
          else       w[int'(grp) * TR + t][c] <= tile[(t*N + c)*DW +: DW];
        end
      grp <= grp_last ? '0 : grp + 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < N; k++)
      for (int c = 0; c < N; c++)
        w_flat[(k*N + c)*DW +: DW] = w[k][c];
  end

  AST_W_STATIONARY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(w_flat)); // R4
endmodule

// File: rtl/mxu_stage.sv
module mxu_stage #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int TR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic               push_bank,
  input  logic [TR*N*DW-1:0] tile,
  input  logic               rd_en,
  input  logic               rd_bank,
  output logic [1:0]         bank_full,
  output logic [N*DW-1:0]    rd_row
);
  localparam int GRPS = N / TR;
  localparam int GW   = (GRPS > 1) ? $clog2(GRPS) : 1;
  localparam int RW   = (N > 1) ? $clog2(N) : 1;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0]   mem [N][N];
    logic [GW-1:0]   wptr;
    logic [GW-1:0]   start;
    logic [RW-1:0]   rptr;
    logic            full_q;
    logic            last;
    logic            wr;
    logic            rd;
    logic [N*DW-1:0] row;

    assign wr = push_en && (push_bank == 1'(b));
    assign rd = rd_en && (rd_bank == 1'(b)) && !wr;

    always_comb begin
      start = full_q ? '0 : wptr;
      last  = (start == GW'(GRPS - 1));
    end

    always_ff @(posedge clk) begin
      if (wr)
        for (int t = 0; t < TR; t++)
          for (int c = 0; c < N; c++)
            mem[int'(start) * TR + t][c] <= tile[(t*N + c)*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wptr   <= '0;
        rptr   <= '0;
        full_q <= 1'b0;
      end else if (wr) begin
        if (last) begin
          full_q <= 1'b1;
          wptr   <= '0;
          rptr   <= '0;
        end else begin
          full_q <= 1'b0;
          wptr   <= start + 1'b1;
        end
      end else if (rd) begin
        if (rptr == RW'(N - 1)) begin
          rptr   <= '0;
          full_q <= 1'b0;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end

    always_comb begin
      for (int c = 0; c < N; c++)
        row[c*DW +: DW] = mem[rptr][c];
    end

    assign bank_full[b] = full_q;
  end

  assign rd_row = rd_bank ? g_bank[1].row : g_bank[0].row;

  AST_BEAT_ON_READY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> bank_full[rd_bank]); // R5
endmodule

// File: rtl/mxu_grid.sv
module mxu_grid #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic [N*DW-1:0]   x_row,
  input  logic [N*N*DW-1:0] w_flat,
  input  logic [1:0]        half,
  output logic [N*AW-1:0]   y_row
);
  import mxu_pkg::*;

  localparam int PW = 2 * DW;
  localparam int HW = AW / 2;

  function automatic logic signed [AW-1:0] pe_mac(input logic signed [AW-1:0] a,
                                                  input logic signed [DW-1:0] x,
                                                  input logic signed [DW-1:0] w);
    logic signed [PW-1:0] p;
    p = x * w;
    return a + {{(AW-PW){p[PW-1]}}, p};
  endfunction

  function automatic logic [AW-1:0] half_shape(input logic [AW-1:0] v, input logic [1:0] h);
    case (h)
      HALF_LOW:  return v & {{(AW-HW){1'b0}}, {HW{1'b1}}};
      HALF_HIGH: return v & {{(AW-HW){1'b1}}, {HW{1'b0}}};
      default:   return v;
    endcase
  endfunction

  for (genvar c = 0; c < N; c++) begin : g_col
    logic signed [AW-1:0] col_sum;
    always_comb begin
      col_sum = '0;
      for (int k = 0; k < N; k++)
        col_sum = pe_mac(col_sum, x_row[k*DW +: DW], w_flat[(k*N + c)*DW +: DW]);
    end
    assign y_row[c*AW +: AW] = half_shape(col_sum, half);
  end
endmodule

// File: rtl/mxu_resq.sv
module mxu_resq #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int FD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [N*AW-1:0] push_row,
  input  logic            pop_en,
  input  logic            pop_acc,
  output logic            full,
  output logic            empty,
  output logic            res_valid,
  output logic [N*AW-1:0] res_row,
  output logic            err_underflow
);
  localparam int PW = (FD > 1) ? $clog2(FD) : 1;
  localparam int CW = $clog2(FD + 1);

  logic [N*AW-1:0] mem [FD];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic [N*AW-1:0] popped, acc_q, acc_nxt;
  logic            pop_hit;

  function automatic logic [N*AW-1:0] lane_merge(input logic [N*AW-1:0] a,
                                                 input logic [N*AW-1:0] b,
                                                 input logic add);
    logic [N*AW-1:0] r;
    for (int l = 0; l < N; l++)
      r[l*AW +: AW] = add ? a[l*AW +: AW] + b[l*AW +: AW] : b[l*AW +: AW];
    return r;
  endfunction

  assign full    = (cnt == CW'(FD));
  assign empty   = (cnt == '0);
  assign pop_hit = pop_en && !empty;
  assign popped  = empty ? '0 : mem[rp];
  assign acc_nxt = lane_merge(acc_q, popped, pop_acc);
  assign cnt_nxt = cnt + CW'(push_en) - CW'(pop_hit);

  always_ff @(posedge clk) begin
    if (push_en) mem[wp] <= push_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp            <= '0;
      rp            <= '0;
      cnt           <= '0;
      acc_q         <= '0;
      res_valid     <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      if (push_en) wp <= (wp == PW'(FD - 1)) ? '0 : wp + 1'b1;
      if (pop_hit) rp <= (rp == PW'(FD - 1)) ? '0 : rp + 1'b1;
      cnt           <= cnt_nxt;
      if (pop_en) acc_q <= acc_nxt;
      res_valid     <= pop_en;
      err_underflow <= pop_en && empty;
    end
  end

  assign res_row = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full); // R12
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en |=> $stable(acc_q)); // R8
  AST_UNDERFLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && empty && !pop_acc) |=> (res_row == '0)); // R10
endmodule

// File: rtl/mxu_seq.sv
module mxu_seq #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32,
  parameter int TR = 2,
  parameter int FD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_xpose,
  input  logic               cmd_bank,
  input  logic [1:0]         cmd_half,
  input  logic               cmd_acc,
  input  logic [TR*N*DW-1:0] cmd_tile,
  output logic               res_valid,
  output logic [N*AW-1:0]    res_row,
  output logic               err_underflow,
  output logic               err_refused
);
  import mxu_pkg::*;

  localparam int ROWW = N * DW;
  localparam int WW   = N * N * DW;
  localparam int RESW = N * AW;

  logic            fire;
  logic            load_en, stage_en, beat_req, beat_ok, beat_refused, drain_en;
  logic [1:0]      bank_full;
  logic            q_full, q_empty;
  logic [ROWW-1:0] x_row;
  logic [WW-1:0]   w_flat;
  logic [RESW-1:0] y_row;

  assign cmd_ready    = !((cmd_op == OP_BEAT) && q_full);
  assign fire         = cmd_valid && cmd_ready;
  assign load_en      = fire && (cmd_op == OP_LOAD);
  assign stage_en     = fire && (cmd_op == OP_STAGE);
  assign beat_req     = fire && (cmd_op == OP_BEAT);
  assign drain_en     = fire && (cmd_op == OP_DRAIN);
  assign beat_ok      = beat_req && bank_full[cmd_bank];
  assign beat_refused = beat_req && !bank_full[cmd_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_refused <= 1'b0;
    else        err_refused <= beat_refused;
  end

  mxu_weights #(.N(N), .DW(DW), .TR(TR)) u_weights (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (load_en),
    .xpose  (cmd_xpose),
    .tile   (cmd_tile),
    .w_flat (w_flat)
  );

  mxu_stage #(.N(N), .DW(DW), .TR(TR)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (stage_en),
    .push_bank (cmd_bank),
    .tile      (cmd_tile),
    .rd_en     (beat_ok),
    .rd_bank   (cmd_bank),
    .bank_full (bank_full),
    .rd_row    (x_row)
  );

  mxu_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .x_row  (x_row),
    .w_flat (w_flat),
    .half   (cmd_half),
    .y_row  (y_row)
  );

  mxu_resq #(.N(N), .AW(AW), .FD(FD)) u_resq (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_en       (beat_ok),
    .push_row      (y_row),
    .pop_en        (drain_en),
    .pop_acc       (cmd_acc),
    .full          (q_full),
    .empty         (q_empty),
    .res_valid     (res_valid),
    .res_row       (res_row),
    .err_underflow (err_underflow)
  );

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, stage_en, beat_ok, drain_en})); // R6
  AST_REFUSED_LEAVES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_refused && q_empty) |=> q_empty); // R11
endmodule

// File: tb/sim_mxu_seq.sv
`timescale 1ns/1ps
module sim_mxu_seq;
  localparam int N = 8, DW = 8, AW = 32, TR = 2, FD = 8;
  localparam int TILEW = TR * N * DW;
  localparam int RESW  = N * AW;

  // columns: seed, transpose, bank, half
  localparam int VEC [6][4] = '{
    '{1,  0, 0, 0},
    '{2,  1, 1, 0},
    '{3,  0, 1, 1},
    '{4,  1, 0, 2},
    '{99, 0, 1, 0},
    '{5,  0, 0, 3}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_xpose = 0, cmd_bank = 0, cmd_acc = 0;
  logic [1:0] cmd_op = 0, cmd_half = 0;
  logic [TILEW-1:0] cmd_tile = '0;
  logic cmd_ready, res_valid, err_underflow, err_refused;
  logic [RESW-1:0] res_row;

  int total = 0, bad = 0;
  int Wm [N][N];
  int Xs [2][N][N];
  int brow [2];
  bit bfull [2];
  logic [RESW-1:0] expq [$];
  logic [RESW-1:0] acc_m = '0;

  always #2.5 clk = ~clk;

  mxu_seq #(.N(N), .DW(DW), .AW(AW), .TR(TR), .FD(FD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_xpose(cmd_xpose), .cmd_bank(cmd_bank), .cmd_half(cmd_half),
    .cmd_acc(cmd_acc), .cmd_tile(cmd_tile), .res_valid(res_valid), .res_row(res_row),
    .err_underflow(err_underflow), .err_refused(err_refused)
  );

  task automatic check(input bit ok, input string req, input logic [RESW-1:0] act,
                       input logic [RESW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gen(int seed, int i, int j);
    if (seed == 99) return -128;
    return ((seed * 37 + i * 11 + j * 7 + i * j * 3) % 256) - 128;
  endfunction

  function automatic logic [RESW-1:0] model_row(int b, int r, int hf);
    logic [RESW-1:0] o;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      logic [31:0] v;
      for (int k = 0; k < N; k++) s += Xs[b][r][k] * Wm[k][c];
      v = s;
      if (hf == 1) v = v & 32'h0000_FFFF;
      if (hf == 2) v = v & 32'hFFFF_0000;
      o[c*AW +: AW] = v;
    end
    return o;
  endfunction

  task automatic issue(input logic [1:0] op, input logic xp, input logic bk,
                       input logic [1:0] hf, input logic ac, input logic [TILEW-1:0] tl);
    @(negedge clk);
    cmd_op = op; cmd_xpose = xp; cmd_bank = bk; cmd_half = hf; cmd_acc = ac; cmd_tile = tl;
    cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_load(int seed, bit xp);
    for (int g = 0; g < N / TR; g++) begin
      logic [TILEW-1:0] tl;
      for (int t = 0; t < TR; t++)
        for (int c = 0; c < N; c++)
          tl[(t*N + c)*DW +: DW] = 8'(gen(seed, g*TR + t, c));
      issue(2'd0, xp, 0, 0, 0, tl);
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        Wm[i][j] = xp ? gen(seed, j, i) : gen(seed, i, j);
  endtask

  task automatic do_stage(int seed, bit bk, int g0, int g1);
    for (int g = g0; g <= g1; g++) begin
      logic [TILEW-1:0] tl;
      for (int t = 0; t < TR; t++)
        for (int c = 0; c < N; c++) begin
          Xs[bk][g*TR + t][c] = gen(seed + 50, g*TR + t, c);
          tl[(t*N + c)*DW +: DW] = 8'(gen(seed + 50, g*TR + t, c));
        end
      issue(2'd1, 0, bk, 0, 0, tl);
    end
    bfull[bk] = (g1 == N / TR - 1);
    brow[bk]  = 0;
  endtask

  task automatic do_beat(bit bk, int hf, string req);
    bit ok = bfull[bk];
    issue(2'd2, 0, bk, 2'(hf), 0, '0);
    if (ok) begin
      expq.push_back(model_row(bk, brow[bk], hf));
      brow[bk]++;
      if (brow[bk] == N) bfull[bk] = 0;
    end
    check(err_refused == !ok, req, RESW'(err_refused), RESW'(!ok));
  endtask

  task automatic do_drain(bit ac, string req);
    logic [RESW-1:0] v = '0;
    bit uf = (expq.size() == 0);
    if (!uf) v = expq.pop_front();
    if (ac) for (int l = 0; l < N; l++) acc_m[l*AW +: AW] = acc_m[l*AW +: AW] + v[l*AW +: AW];
    else    acc_m = v;
    issue(2'd3, 0, 0, 0, ac, '0);
    check(res_valid && (err_underflow == uf) && (res_row == acc_m), req, res_row, acc_m);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(cmd_ready && !res_valid && !err_underflow && !err_refused, "R1",
          RESW'({cmd_ready, res_valid, err_underflow, err_refused}), RESW'(4'b1000));
    // R1 R10: drain on empty, accumulator starts at zero
    do_drain(0, "R10");

    // table walk: R2 R3 R6 R7
    for (int e = 0; e < 6; e++) begin
      string req = (e == 0) ? "R2" : (VEC[e][1] != 0) ? "R3" :
                   (VEC[e][3] == 1 || VEC[e][3] == 2) ? "R7" : "R6";
      do_load(VEC[e][0], VEC[e][1] != 0);
      do_stage(VEC[e][0], VEC[e][2] != 0, 0, N / TR - 1);
      for (int r = 0; r < N; r++) do_beat(VEC[e][2] != 0, VEC[e][3], "R5");
      for (int r = 0; r < N; r++) do_drain(0, req);
    end

    // R4: weights from the last load are reused with a new operand
    do_stage(7, 1, 0, N / TR - 1);
    for (int r = 0; r < N; r++) do_beat(1, 0, "R5");
    for (int r = 0; r < N; r++) do_drain(0, "R4");

    // R11: beat on an emptied bank, then on a partly staged bank
    do_beat(0, 0, "R11");
    do_drain(0, "R11");
    do_stage(8, 0, 0, 0);
    do_beat(0, 0, "R11");
    do_stage(8, 0, 1, N / TR - 1);

    // R7 R8 R9: halves recombined through the accumulator
    do_beat(0, 1, "R7");
    do_beat(0, 2, "R7");
    do_beat(0, 0, "R6");
    do_drain(0, "R8");
    do_drain(1, "R9");
    do_drain(1, "R9");
    @(negedge clk);
    check(!res_valid && !err_underflow, "R8", RESW'(res_valid), '0);
    // R10: accumulating drain on empty keeps the accumulator
    do_drain(1, "R10");

    // R12: fill the queue to FD rows
    do_stage(9, 1, 0, N / TR - 1);
    for (int r = 0; r < 5; r++) do_beat(0, 0, "R5");
    for (int r = 0; r < 3; r++) do_beat(1, 0, "R5");
    @(negedge clk);
    cmd_op = 2'd2; cmd_bank = 1; cmd_valid = 1;
    #1;
    check(cmd_ready == 0, "R12", RESW'(cmd_ready), '0);
    cmd_op = 2'd3;
    #1;
    check(cmd_ready == 1, "R12", RESW'(cmd_ready), RESW'(1));
    cmd_valid = 0;
    do_drain(0, "R12");
    do_beat(1, 0, "R12");
    for (int r = 0; r < FD; r++) do_drain(0, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule